// File: doc/BRIEF.md
# Per-Domain Cache Placement Seed Controller

This block feeds the randomized-placement logic of a cache with the seed that is currently in force. It keeps a seed for every isolation domain (one software component and all of its tasks) and a separate seed for the operating system. Tasks in the same component share that component's seed, so their shared data maps consistently. Two domains never hold the same value. A free-running linear feedback shift register supplies fresh values. Whenever the full seed set is drawn, a draw that matches a seed already placed in that set is discarded and drawn again.

Context changes are switching a component, entering the operating system and leaving it. On each of these the controller asks the pipeline to drain and waits until no memory access of the outgoing context is in flight. Only then does it load the new seed, and it never flushes the cache for a context change. Once per hyperperiod, a tick makes it drain, request a cache flush and wait for the acknowledge. It then redraws every seed. Requests that arrive while a sequence is running are held and served afterwards, and a pending tick is served before a pending context change.

Top module: `pseed_ctrl`

## Requirements
- R1: During reset seed_out is 0 and flush_req is low. After reset the controller draws a full seed set with drain_req high and without a flush, then shows the operating-system seed. No seed is ever 0.
- R2: Every return to a domain, or to the operating-system context, presents the same seed as its previous visit, as long as no hyperperiod reseed has taken place in between.
- R3: The seeds of all domains and of the operating system are pairwise different within one seed set.
- R4: os_enter makes the operating-system seed active. os_exit restores the seed of the domain most recently selected by sw_req (domain 0 after reset).
- R5: After a context-change request, drain_req is high and seed_out holds its old value for as long as inflight is nonzero. The new seed appears within two cycles after inflight reaches 0.
- R6: Context changes never raise flush_req.
- R7: A single-cycle pulse on hp_tick leads to a drain, then one flush_req window that lasts until flush_ack, then a fresh seed set. The active seed after the reseed differs from the one before.
- R8: Each serviced hp_tick gives exactly one rising edge of flush_req, and flush_req stays high until flush_ack is seen.
- R9: A context-change request that arrives during a flush or a reseed leaves seed_out unchanged. It is carried out after the reseed, using the new seed set.
- R10: An hp_tick that arrives while a drain is waiting on inflight does not start a flush before that drain ends. The drain completes its swap to the old seed of the target, and the flush follows straight after.
- R11: seed_out changes only in a cycle that follows a cycle in which drain_req was high. It stays constant while the controller is idle.
- R12: When strobes coincide, os_enter has priority over sw_req, and sw_req has priority over os_exit. A sw_req that loses is dropped and does not change the domain that os_exit restores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_req | input | 1 | One-cycle strobe: switch to domain sw_dom |
| sw_dom | input | $clog2(NUM_DOM) | Target domain of sw_req |
| os_enter | input | 1 | One-cycle strobe: operating system takes over |
| os_exit | input | 1 | One-cycle strobe: operating system returns to its domain |
| hp_tick | input | 1 | One-cycle strobe at each hyperperiod boundary |
| inflight | input | INFL_W | Number of memory accesses not yet completed |
| flush_ack | input | 1 | Cache reports the flush as done |
| seed_out | output | SEED_W | Active placement seed |
| drain_req | output | 1 | High while a change sequence needs the pipeline held |
| flush_req | output | 1 | Cache flush request, held until flush_ack |

## Verification
A corrupted seed table shows up at the next visit to any domain. The seed on seed_out then either fails to repeat its earlier value or matches another domain's seed, and this is visible as soon as the swap that follows the drain lands. A sequencer in the wrong state can change seed_out without a preceding drain cycle or while inflight is nonzero. It can also hold drain_req high forever or give zero or two flush edges for one tick. A monitor catches each of these in the cycle it happens. Held requests and the tick-during-drain ordering are driven as directed cases. Random context sequences with random in-flight counts run alongside them.

// File: rtl/pseed_pkg.sv
package pseed_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DRAIN,
      ST_SWAP,
      ST_FLUSH,
      ST_RESEED
   } pseed_state_e;

endpackage

// File: rtl/pseed_lfsr.sv
module pseed_lfsr #(
   parameter int              W    = 32,
   parameter logic [W-1:0]    INIT = W'(32'h5EED_C0DE)
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] q
);

   logic fb;

   generate
      if (W == 32) begin : g_w32
         assign fb = q[31] ^ q[21] ^ q[1] ^ q[0];
      end else if (W == 16) begin : g_w16
         assign fb = q[15] ^ q[14] ^ q[12] ^ q[3];
      end else begin : g_bad_w
         $error("pseed_lfsr: W must be 16 or 32");
      end
      if (INIT == '0) begin : g_bad_init
         $error("pseed_lfsr: INIT must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= INIT;
      else        q <= {q[W-2:0], fb};
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      q != '0); // R1

endmodule

// File: rtl/pseed_table.sv
module pseed_table #(
   parameter int W        = 32,
   parameter int NUM_SLOT = 5,
   parameter int SLOT_W   = $clog2(NUM_SLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_idx,
   input  logic [W-1:0]      wr_data,
   input  logic [SLOT_W-1:0] rd_idx,
   output logic [W-1:0]      rd_data,
   input  logic [W-1:0]      chk_data,
   input  logic [SLOT_W-1:0] chk_lim,
   output logic              hit
);

   logic [W-1:0]        mem [NUM_SLOT];
   logic [NUM_SLOT-1:0] eq;

   generate
      if (NUM_SLOT < 2) begin : g_bad_slots
         $error("pseed_table: need at least two slots");
      end
      for (genvar i = 0; i < NUM_SLOT; i++) begin : g_cmp
         assign eq[i] = (SLOT_W'(i) < chk_lim) && (mem[i] == chk_data);
      end
   endgenerate

   assign hit     = |eq;
   assign rd_data = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_SLOT; k++) mem[k] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   AST_TBL_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !hit); // R3

endmodule

// File: rtl/pseed_ctrl.sv
module pseed_ctrl
   import pseed_pkg::*;
#(
   parameter int                 SEED_W    = 32,
   parameter int                 NUM_DOM   = 4,
   parameter int                 INFL_W    = 4,
   parameter logic [SEED_W-1:0]  LFSR_INIT = SEED_W'(32'h5EED_C0DE)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sw_req,
   input  logic [$clog2(NUM_DOM)-1:0] sw_dom,
   input  logic                       os_enter,
   input  logic                       os_exit,
   input  logic                       hp_tick,
   input  logic [INFL_W-1:0]          inflight,
   input  logic                       flush_ack,
   output logic [SEED_W-1:0]          seed_out,
   output logic                       drain_req,
   output logic                       flush_req
);

   localparam int DOM_W    = $clog2(NUM_DOM);
   localparam int NUM_SLOT = NUM_DOM + 1;
   localparam int SLOT_W   = $clog2(NUM_SLOT);
   localparam logic [SLOT_W-1:0] OS_SLOT = SLOT_W'(NUM_DOM);

   generate
      if (NUM_DOM < 2) begin : g_bad_dom
         $error("pseed_ctrl: NUM_DOM must be at least 2");
      end
      if (INFL_W < 1) begin : g_bad_infl
         $error("pseed_ctrl: INFL_W must be at least 1");
      end
   endgenerate

   pseed_state_e       st;
   logic               cur_os, t_os, p_os, p_ctx, p_tick, for_flush;
   logic [DOM_W-1:0]   cur_dom, t_dom, home_dom;
   logic [SLOT_W-1:0]  idx, rd_idx;
   logic [SEED_W-1:0]  cand, rd_data;
   logic               hit, tbl_we;

   pseed_lfsr #(.W(SEED_W), .INIT(LFSR_INIT)) u_lfsr (
      .clk (clk), .rst_n (rst_n), .q (cand)
   );

   pseed_table #(.W(SEED_W), .NUM_SLOT(NUM_SLOT), .SLOT_W(SLOT_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we),
      .wr_idx   (idx),
      .wr_data  (cand),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data),
      .chk_data (cand),
      .chk_lim  (idx),
      .hit      (hit)
   );

   always_comb begin
      drain_req = (st != ST_IDLE);
      flush_req = (st == ST_FLUSH);
      tbl_we    = (st == ST_RESEED) && !hit;
      if (st == ST_RESEED) rd_idx = SLOT_W'(cur_dom);
      else if (t_os)       rd_idx = OS_SLOT;
      else                 rd_idx = SLOT_W'(t_dom);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_RESEED;
         idx       <= '0;
         cur_os    <= 1'b1;
         cur_dom   <= '0;
         home_dom  <= '0;
         t_os      <= 1'b1;
         t_dom     <= '0;
         p_os      <= 1'b0;
         p_ctx     <= 1'b0;
         p_tick    <= 1'b0;
         for_flush <= 1'b0;
         seed_out  <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (p_tick) begin
                  p_tick    <= 1'b0;
                  for_flush <= 1'b1;
                  st        <= ST_DRAIN;
               end else if (p_ctx) begin
                  p_ctx     <= 1'b0;
                  t_os      <= p_os;
                  t_dom     <= home_dom;
                  for_flush <= 1'b0;
                  st        <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (inflight == '0) st <= for_flush ? ST_FLUSH : ST_SWAP;
            end
            ST_SWAP: begin
               seed_out <= rd_data;
               cur_os   <= t_os;
               cur_dom  <= t_dom;
               st       <= ST_IDLE;
            end
            ST_FLUSH: begin
               if (flush_ack) begin
                  idx <= '0;
                  st  <= ST_RESEED;
               end
            end
            ST_RESEED: begin
               if (!hit) begin
                  if (idx == OS_SLOT) begin
                     seed_out <= cur_os ? cand : rd_data;
                     st       <= ST_IDLE;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase

         if (hp_tick) p_tick <= 1'b1;
         if (os_enter) begin
            p_ctx <= 1'b1;
            p_os  <= 1'b1;
         end else if (sw_req) begin
            p_ctx    <= 1'b1;
            p_os     <= 1'b0;
            home_dom <= sw_dom;
         end else if (os_exit) begin
            p_ctx <= 1'b1;
            p_os  <= 1'b0;
         end
      end
   end

   AST_SEED_ONLY_AFTER_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(seed_out) |-> $past(st == ST_SWAP || st == ST_RESEED)); // R11

   AST_SWAP_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SWAP) |-> ($past(inflight) == '0)); // R5

   AST_FLUSH_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flush_req) |-> ($past(inflight) == '0)); // R7

   AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req && !flush_ack) |=> flush_req); // R8

   AST_SEED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> (seed_out != '0)); // R1

endmodule

// File: tb/pseed_ctrl_bench.sv
module pseed_ctrl_bench;

   localparam int CLK_P = 10;
   localparam int ND    = 4;
   localparam int SW    = 32;
   localparam int IW    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_req = 1'b0, os_enter = 1'b0, os_exit = 1'b0, hp_tick = 1'b0;
   logic [1:0]    sw_dom = '0;
   logic [IW-1:0] inflight = '0;
   logic          flush_ack = 1'b0;
   logic [SW-1:0] seed_out;
   logic          drain_req, flush_req;

   pseed_ctrl #(.SEED_W(SW), .NUM_DOM(ND), .INFL_W(IW)) u_pseed_ctrl (
      .clk (clk), .rst_n (rst_n), .sw_req (sw_req), .sw_dom (sw_dom),
      .os_enter (os_enter), .os_exit (os_exit), .hp_tick (hp_tick),
      .inflight (inflight), .flush_ack (flush_ack), .seed_out (seed_out),
      .drain_req (drain_req), .flush_req (flush_req)
   );

   initial forever #(CLK_P/2) clk = ~clk;

   int checks = 0, fails = 0, flush_cnt = 0, cycles = 0;
   logic [SW-1:0] known_seed [ND+1];
   bit            known [ND+1];
   bit            exp_os = 1'b1;
   int            exp_dom = 0;

   task automatic chk(input bit ok, input string req, input logic [SW-1:0] act,
                      input logic [SW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int slot_of(input bit os, input int dom);
      return os ? ND : dom;
   endfunction

   task automatic forget_all();
      for (int i = 0; i <= ND; i++) known[i] = 1'b0;
   endtask

   task automatic wait_quiet();
      int g = 0;
      while (drain_req && g < 2000) begin @(negedge clk); g++; end
      if (g >= 2000) chk(1'b0, "R5 drain never ends", 32'(drain_req), 0);
   endtask

   task automatic wait_settle();
      wait_quiet();
      repeat (3) @(negedge clk);
      wait_quiet();
   endtask

   // Compare the active seed with the model, or learn it and check uniqueness
   task automatic expect_ctx();
      int s = slot_of(exp_os, exp_dom);
      if (known[s]) begin
         chk(seed_out == known_seed[s], "R2 seed repeats on revisit", seed_out, known_seed[s]);
      end else begin
         chk(seed_out != '0, "R1 seed nonzero", seed_out, 1);
         for (int i = 0; i <= ND; i++)
            if (known[i]) chk(seed_out != known_seed[i], "R3 seeds distinct", seed_out, known_seed[i]);
         known[s] = 1'b1;
         known_seed[s] = seed_out;
      end
   endtask

   // kind: 0 switch, 1 os enter, 2 os exit, 3 enter and switch together
   task automatic request(input int kind, input int dom, input int infl);
      logic [SW-1:0] old;
      @(negedge clk);
      inflight = IW'(infl);
      sw_dom   = 2'(dom);
      sw_req   = (kind == 0 || kind == 3);
      os_enter = (kind == 1 || kind == 3);
      os_exit  = (kind == 2);
      @(negedge clk);
      sw_req = 1'b0; os_enter = 1'b0; os_exit = 1'b0;
      @(negedge clk);
      if (infl > 0) begin
         old = seed_out;
         repeat (5) @(negedge clk);
         chk(drain_req && seed_out == old, "R5 seed held while accesses pending", seed_out, old);
         inflight = '0;
      end
      wait_settle();
      case (kind)
         0: begin exp_os = 1'b0; exp_dom = dom; end
         1: exp_os = 1'b1;
         2: exp_os = 1'b0;
         default: exp_os = 1'b1;
      endcase
      expect_ctx();
   endtask

   task automatic do_tick();
      logic [SW-1:0] prev = seed_out;
      int f0 = flush_cnt;
      @(negedge clk); hp_tick = 1'b1;
      @(negedge clk); hp_tick = 1'b0;
      @(negedge clk);
      wait_settle();
      chk(flush_cnt == f0 + 1, "R8 one flush per tick", 32'(flush_cnt), 32'(f0 + 1));
      chk(seed_out != prev, "R7 new seed after reseed", seed_out, prev);
      forget_all();
      expect_ctx();
   endtask

   // Cache model: acknowledge a flush three cycles after the request
   initial forever begin
      @(negedge clk);
      if (flush_req && !flush_ack) begin
         repeat (3) @(negedge clk);
         flush_ack = 1'b1;
         @(negedge clk);
         flush_ack = 1'b0;
      end
   end

   // Monitor: seed changes, flush edges, watchdog
   initial begin
      logic [SW-1:0] p_seed = '0;
      logic p_drain = 1'b0, p_flush = 1'b0;
      logic [IW-1:0] p_infl = '0;
      forever begin
         @(negedge clk);
         cycles++;
         if (rst_n) begin
            if (flush_req && !p_flush) flush_cnt++;
            if (seed_out != p_seed) begin
               chk(p_drain, "R11 seed changed without drain", seed_out, p_seed);
               chk(p_infl == '0, "R5 seed changed with accesses pending", 32'(p_infl), 0);
            end
         end
         p_seed = seed_out; p_drain = drain_req; p_flush = flush_req; p_infl = inflight;
         if (cycles > 150000) begin
            chk(1'b0, "watchdog expired", 32'(cycles), 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      logic [SW-1:0] old, dom3_seed;
      int f0;
      forget_all();
      void'($urandom(32'd1234));

      // Reset state and initial seeding (R1)
      repeat (4) @(negedge clk);
      chk(seed_out == '0, "R1 seed zero in reset", seed_out, 0);
      chk(!flush_req, "R1 no flush in reset", 32'(flush_req), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(drain_req, "R1 drain during initial seeding", 32'(drain_req), 1);
      wait_quiet();
      chk(flush_cnt == 0, "R1 no flush at initial seeding", 32'(flush_cnt), 0);
      expect_ctx();

      // Visit every domain, then revisit (R2, R3)
      for (int d = 0; d < ND; d++) request(0, d, 0);
      request(0, 1, 0);
      // Operating system entry and exit (R4)
      request(1, 0, 0);
      request(2, 0, 0);
      chk(seed_out == known_seed[1], "R4 exit restores domain seed", seed_out, known_seed[1]);
      // Drain with pending accesses (R5)
      request(0, 2, 3);
      // Coincident strobes: enter wins, switch dropped (R12)
      request(3, 0, 0);
      chk(seed_out == known_seed[ND], "R12 enter beats switch", seed_out, known_seed[ND]);
      request(2, 0, 0);
      chk(seed_out == known_seed[2], "R12 dropped switch leaves home domain", seed_out, known_seed[2]);
      // No flush for context changes (R6)
      chk(flush_cnt == 0, "R6 no flush on context change", 32'(flush_cnt), 0);

      // Hyperperiod reseed (R7, R8)
      do_tick();

      // Switch requested during flush is held (R9)
      old = known_seed[slot_of(exp_os, exp_dom)];
      f0 = flush_cnt;
      @(negedge clk); hp_tick = 1'b1;
      @(negedge clk); hp_tick = 1'b0;
      while (!flush_req) @(negedge clk);
      sw_req = 1'b1; sw_dom = 2'd3;
      @(negedge clk); sw_req = 1'b0;
      chk(seed_out == old, "R9 seed held during flush", seed_out, old);
      wait_settle();
      chk(flush_cnt == f0 + 1, "R9 single flush", 32'(flush_cnt), 32'(f0 + 1));
      forget_all();
      exp_os = 1'b0; exp_dom = 3;
      expect_ctx();
      request(0, 1, 0);
      dom3_seed = known_seed[3];

      // Tick during drain is serviced after the swap (R10)
      f0 = flush_cnt;
      @(negedge clk);
      inflight = 2; sw_req = 1'b1; sw_dom = 2'd3;
      @(negedge clk); sw_req = 1'b0;
      repeat (3) @(negedge clk);
      hp_tick = 1'b1;
      @(negedge clk); hp_tick = 1'b0;
      repeat (4) @(negedge clk);
      chk(flush_cnt == f0 && drain_req, "R10 no flush while draining", 32'(flush_cnt), 32'(f0));
      old = seed_out;
      inflight = '0;
      begin
         int g = 0;
         while (seed_out == old && g < 100) begin @(negedge clk); g++; end
      end
      chk(seed_out == dom3_seed, "R10 swap uses old seed set", seed_out, dom3_seed);
      wait_settle();
      chk(flush_cnt == f0 + 1, "R10 flush follows swap", 32'(flush_cnt), 32'(f0 + 1));
      chk(seed_out != dom3_seed, "R10 reseed after swap", seed_out, dom3_seed);
      forget_all();
      exp_os = 1'b0; exp_dom = 3;
      expect_ctx();

      // Random context traffic
      for (int it = 0; it < 40; it++) begin
         int r = $urandom_range(0, 4);
         if (r == 4) begin
            old = seed_out;
            repeat ($urandom_range(2, 20)) @(negedge clk);
            chk(seed_out == old, "R11 seed stable while idle", seed_out, old);
         end else begin
            request(r, $urandom_range(0, ND - 1), $urandom_range(0, 3));
         end
      end
      f0 = flush_cnt;
      do_tick();
      chk(flush_cnt == f0 + 1, "R6 R8 flush count after traffic", 32'(flush_cnt), 32'(f0 + 1));
      for (int d = 0; d < ND; d++) request(0, d, 1);
      request(1, 0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule